// File: doc/BRIEF.md
# Program Memory Table Access Unit

This block gives a 16-bit data-side port read, write and erase access to an instruction memory whose words are 24 bits wide. A page register of 8 bits sits above a 16-bit effective address to form a 24-bit program address. The top address bit picks between the user space and a small configuration space. Each instruction takes two effective-address units, so the instruction index is the formed address shifted right by one, and address bit 0 only selects a byte.

A table access works on one half of an instruction at a time. The low half is instruction bits 15:0 and the high half is bits 23:16. Each half can be accessed as a word or as a byte. Table writes never touch the array directly: they fill a row latch buffer. A start strobe then commits either the single addressed instruction or a whole row of latched instructions, or erases a whole page. Programming can only clear bits, erased cells read as all ones, and the unit reports busy until the operation ends.

Top module: `pmem_table_unit`

## Requirements
- R1: The formed address is {page register, effective address}. Its bit 23 (page bit 7) selects the configuration space when 1 and the user space when 0, and bits 22:1 give the instruction index. `page_q` shows the page register, which is loaded by `page_we`. An index at or beyond a space's depth reads as all ones and ignores programming.
- R2: Every location reads as erased (24'hFFFFFF) after power-up.
- R3: A table read accepted while idle raises `rd_valid` for exactly one cycle, in the cycle after the access. A low-half word read returns bits 15:0. A low-half byte read returns {8'h00, bits 7:0} when EA bit 0 = 0 and {8'h00, bits 15:8} when EA bit 0 = 1.
- R4: A high-half word read returns {8'h00, bits 23:16}. A high-half byte read returns the same value when EA bit 0 = 0 and 16'h0000 when EA bit 0 = 1.
- R5: A table write loads latch entry (index mod 64) and leaves the array unchanged. The lanes are:
  - low word: bits 15:0 take wdata;
  - low byte: bits 7:0 (EA bit 0 = 0) or bits 15:8 (EA bit 0 = 1) take wdata[7:0];
  - high word, or high byte with EA bit 0 = 0: bits 23:16 take wdata[7:0];
  - high byte with EA bit 0 = 1: no effect.
- R6: A start with `prog_op` = 2'b00 programs only the addressed instruction from latch entry (index mod 64). `busy` is high for exactly one cycle.
- R7: A start with `prog_op` = 2'b01 programs the 64 instructions of the 64-aligned row that holds the index, taking entry k for row offset k. `busy` is high for 64 cycles, and afterwards every latch entry holds all ones.
- R8: A start with `prog_op` = 2'b10 sets every instruction of the 512-aligned page that holds the index to all ones. `busy` is high for 512 cycles.
- R9: Programming stores the old contents AND the latch data, so it can only clear bits.
- R10: While `busy` is high, table reads, table writes and start strobes are ignored. A table access in the same cycle as an accepted start is also ignored.
- R11: A start with `prog_op` = 2'b11 does nothing and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| page_we | input | 1 | Load the page register |
| page_wdata | input | 8 | New page register value |
| page_q | output | 8 | Current page register |
| acc_valid | input | 1 | Table access request |
| acc_write | input | 1 | 1 = table write, 0 = table read |
| acc_high | input | 1 | 1 = high half (bits 23:16), 0 = low half (bits 15:0) |
| acc_byte | input | 1 | 1 = byte mode, 0 = word mode |
| acc_ea | input | 16 | Effective address of the access |
| acc_wdata | input | 16 | Table write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 16 | Read data |
| prog_start | input | 1 | Start strobe for a program or erase operation |
| prog_op | input | 2 | 00 single, 01 row, 10 page erase, 11 none |
| prog_ea | input | 16 | Effective address of the program or erase target |
| busy | output | 1 | Operation in progress |

## Verification
The read path is tried with every mix of half, mode and byte select on one instruction whose three bytes all differ, so a swapped lane or a missing zero fill shows up as a wrong byte. Writes use:
- each lane pattern, including the ignored upper high byte, followed by a program and a read-back;
- a second program over data already programmed, which tells AND-with-old apart from plain overwrite;
- a full row written with index-dependent values and committed from an unaligned address, which exposes wrong alignment or wrong entry order.

Busy-window counts for each operation, accesses injected during an erase, and a program through a latch entry after a row commit separate a correct busy gate and latch reset from a leaky one.

// File: rtl/pmt_pkg.sv
package pmt_pkg;

    localparam int INSN_W = 24;
    localparam int EA_W   = 16;
    localparam int PAGE_W = 8;
    localparam int ADDR_W = PAGE_W + EA_W;
    localparam int IDX_W  = ADDR_W - 2;

    typedef enum logic [1:0] {
        OP_SINGLE = 2'b00,
        OP_ROW    = 2'b01,
        OP_ERASE  = 2'b10,
        OP_NONE   = 2'b11
    } prog_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SINGLE,
        ST_ROW,
        ST_ERASE
    } ctl_state_e;

endpackage

// File: rtl/pmt_addr.sv
module pmt_addr
    import pmt_pkg::*;
(
    input  logic [PAGE_W-1:0] page,
    input  logic [EA_W-1:0]   ea,
    output logic              space_cfg,
    output logic [IDX_W-1:0]  idx,
    output logic              byte_sel
);
    logic [ADDR_W-1:0] full_addr;

    always_comb begin
        full_addr = {page, ea};
        space_cfg = full_addr[ADDR_W-1];
        idx       = full_addr[ADDR_W-2:1];
        byte_sel  = full_addr[0];
    end
endmodule

// File: rtl/pmt_row_latch.sv
module pmt_row_latch #(
    parameter int ENTRIES = 64,
    parameter int W       = 24,
    localparam int IW     = $clog2(ENTRIES),
    localparam int LANES  = W / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IW-1:0]    widx,
    input  logic [LANES-1:0] wmask,
    input  logic [W-1:0]     wdata,
    input  logic             clr,
    input  logic [IW-1:0]    ridx,
    output logic [W-1:0]     rdata
);
    logic [W-1:0] lat_q [ENTRIES];
    logic [W-1:0] lat_d [ENTRIES];

    always_comb begin
        lat_d = lat_q;
        if (clr) begin
            for (int e = 0; e < ENTRIES; e++) lat_d[e] = '1;
        end else if (we) begin
            for (int b = 0; b < LANES; b++) begin
                if (wmask[b]) lat_d[widx][8*b +: 8] = wdata[8*b +: 8];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) lat_q[e] <= '1;
        end else begin
            lat_q <= lat_d;
        end
    end

    assign rdata = lat_q[ridx];

    // R7: a row commit leaves the latch fully reset
    a_r7_latch_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr) |-> (lat_q[0] == '1 && lat_q[ENTRIES-1] == '1));
endmodule

// File: rtl/pmt_array.sv
module pmt_array #(
    parameter int DEPTH = 1024,
    parameter int IDX_W = 22,
    parameter int W     = 24,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [W-1:0]     rd_q,
    input  logic             we,
    input  logic             erase,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [W-1:0]     wr_data
);
    localparam logic [IDX_W:0] DEPTH_X = (IDX_W + 1)'(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [W-1:0] rd_d;
    logic         rd_in, wr_in;
    logic [AW-1:0] rd_a, wr_a;

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = '1;
    end

    always_comb begin
        rd_in = ({1'b0, rd_idx} < DEPTH_X);
        wr_in = ({1'b0, wr_idx} < DEPTH_X);
        rd_a  = rd_idx[AW-1:0];
        wr_a  = wr_idx[AW-1:0];
        rd_d  = rd_q;
        if (rd_en) rd_d = rd_in ? mem[rd_a] : '1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '1;
        else        rd_q <= rd_d;
    end

    always_ff @(posedge clk) begin
        if (we && wr_in) begin
            if (erase) mem[wr_a] <= '1;
            else       mem[wr_a] <= mem[wr_a] & wr_data;
        end
    end

    // observation registers for the checks below
    logic          pw_q, ew_q;
    logic [AW-1:0] chk_a_q;
    logic [W-1:0]  old_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pw_q    <= 1'b0;
            ew_q    <= 1'b0;
            chk_a_q <= '0;
            old_q   <= '0;
        end else begin
            pw_q    <= we && wr_in && !erase;
            ew_q    <= we && wr_in && erase;
            chk_a_q <= wr_a;
            old_q   <= mem[wr_a];
        end
    end

    // R9: a program write never sets a bit that was clear
    a_r9_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
        pw_q |-> ((mem[chk_a_q] & ~old_q) == '0));

    // R8: an erase write leaves the cell all ones
    a_r8_erased_ones: assert property (@(posedge clk) disable iff (!rst_n)
        ew_q |-> (mem[chk_a_q] == '1));
endmodule

// File: rtl/pmem_table_unit.sv
module pmem_table_unit
    import pmt_pkg::*;
#(
    parameter int ROW_INSNS  = 64,
    parameter int PAGE_INSNS = 512,
    parameter int USER_INSNS = 1024,
    parameter int CFG_INSNS  = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        page_we,
    input  logic [7:0]  page_wdata,
    output logic [7:0]  page_q,
    input  logic        acc_valid,
    input  logic        acc_write,
    input  logic        acc_high,
    input  logic        acc_byte,
    input  logic [15:0] acc_ea,
    input  logic [15:0] acc_wdata,
    output logic        rd_valid,
    output logic [15:0] rd_data,
    input  logic        prog_start,
    input  logic [1:0]  prog_op,
    input  logic [15:0] prog_ea,
    output logic        busy
);
    localparam int ROW_W = $clog2(ROW_INSNS);
    localparam int CNT_W = $clog2(PAGE_INSNS);
    localparam logic [IDX_W-1:0] ROW_MASK  = IDX_W'(ROW_INSNS - 1);
    localparam logic [IDX_W-1:0] PAGE_MASK = IDX_W'(PAGE_INSNS - 1);
    localparam logic [CNT_W-1:0] ROW_LAST  = CNT_W'(ROW_INSNS - 1);
    localparam logic [CNT_W-1:0] PAGE_LAST = CNT_W'(PAGE_INSNS - 1);

    typedef struct packed {
        ctl_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  base;
        logic              space;
        logic [PAGE_W-1:0] page;
        logic              rd_valid;
        logic              rd_high;
        logic              rd_byte;
        logic              rd_sel;
        logic              rd_space;
    } ctl_s;

    ctl_s q, d;

    // address formation (an accepted start owns the address path)
    logic [EA_W-1:0]  sel_ea;
    logic             a_space, a_sel;
    logic [IDX_W-1:0] a_idx;

    assign sel_ea = prog_start ? prog_ea : acc_ea;

    pmt_addr u_addr (
        .page      (q.page),
        .ea        (sel_ea),
        .space_cfg (a_space),
        .idx       (a_idx),
        .byte_sel  (a_sel)
    );

    // row latch
    logic              lat_we, lat_clr;
    logic [2:0]        lat_mask;
    logic [INSN_W-1:0] lat_wdata, lat_rdata;
    logic [ROW_W-1:0]  lat_ridx;

    pmt_row_latch #(.ENTRIES(ROW_INSNS), .W(INSN_W)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (lat_we),
        .widx  (a_idx[ROW_W-1:0]),
        .wmask (lat_mask),
        .wdata (lat_wdata),
        .clr   (lat_clr),
        .ridx  (lat_ridx),
        .rdata (lat_rdata)
    );

    // array control
    logic              arr_re, arr_we, arr_erase, arr_wspace;
    logic [IDX_W-1:0]  arr_widx;
    logic [INSN_W-1:0] space_q [2];

    localparam int SPACE_DEPTH [2] = '{USER_INSNS, CFG_INSNS};

    for (genvar s = 0; s < 2; s++) begin : g_space
        pmt_array #(.DEPTH(SPACE_DEPTH[s]), .IDX_W(IDX_W), .W(INSN_W)) u_arr (
            .clk     (clk),
            .rst_n   (rst_n),
            .rd_en   (arr_re && (a_space == 1'(s))),
            .rd_idx  (a_idx),
            .rd_q    (space_q[s]),
            .we      (arr_we && (arr_wspace == 1'(s))),
            .erase   (arr_erase),
            .wr_idx  (arr_widx),
            .wr_data (lat_rdata)
        );
    end

    always_comb begin
        d          = q;
        d.rd_valid = 1'b0;
        lat_we     = 1'b0;
        lat_clr    = 1'b0;
        lat_mask   = 3'b000;
        lat_wdata  = '0;
        lat_ridx   = '0;
        arr_re     = 1'b0;
        arr_we     = 1'b0;
        arr_erase  = 1'b0;
        arr_wspace = q.space;
        arr_widx   = q.base | IDX_W'(q.cnt);

        if (page_we) d.page = page_wdata;

        unique case (q.st)
            ST_IDLE: begin
                if (prog_start) begin
                    d.space = a_space;
                    d.cnt   = '0;
                    unique case (prog_op_e'(prog_op))
                        OP_SINGLE: begin
                            d.st   = ST_SINGLE;
                            d.base = a_idx;
                        end
                        OP_ROW: begin
                            d.st   = ST_ROW;
                            d.base = a_idx & ~ROW_MASK;
                        end
                        OP_ERASE: begin
                            d.st   = ST_ERASE;
                            d.base = a_idx & ~PAGE_MASK;
                        end
                        default: d.st = ST_IDLE;
                    endcase
                end else if (acc_valid && acc_write) begin
                    lat_we = 1'b1;
                    if (!acc_high) begin
                        if (!acc_byte) begin
                            lat_mask  = 3'b011;
                            lat_wdata = {8'h00, acc_wdata};
                        end else if (!a_sel) begin
                            lat_mask  = 3'b001;
                            lat_wdata = {16'h0000, acc_wdata[7:0]};
                        end else begin
                            lat_mask  = 3'b010;
                            lat_wdata = {8'h00, acc_wdata[7:0], 8'h00};
                        end
                    end else if (!(acc_byte && a_sel)) begin
                        lat_mask  = 3'b100;
                        lat_wdata = {acc_wdata[7:0], 16'h0000};
                    end
                end else if (acc_valid) begin
                    arr_re     = 1'b1;
                    d.rd_valid = 1'b1;
                    d.rd_high  = acc_high;
                    d.rd_byte  = acc_byte;
                    d.rd_sel   = a_sel;
                    d.rd_space = a_space;
                end
            end
            ST_SINGLE: begin
                arr_we   = 1'b1;
                arr_widx = q.base;
                lat_ridx = q.base[ROW_W-1:0];
                d.st     = ST_IDLE;
            end
            ST_ROW: begin
                arr_we   = 1'b1;
                lat_ridx = q.cnt[ROW_W-1:0];
                if (q.cnt == ROW_LAST) begin
                    lat_clr = 1'b1;
                    d.st    = ST_IDLE;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_ERASE: begin
                arr_we    = 1'b1;
                arr_erase = 1'b1;
                if (q.cnt == PAGE_LAST) d.st = ST_IDLE;
                else                    d.cnt = q.cnt + 1'b1;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    // read formatting
    logic [INSN_W-1:0] rd_word;

    always_comb begin
        rd_word = space_q[q.rd_space];
        if (!q.rd_high) begin
            if (!q.rd_byte)     rd_data = rd_word[15:0];
            else if (!q.rd_sel) rd_data = {8'h00, rd_word[7:0]};
            else                rd_data = {8'h00, rd_word[15:8]};
        end else begin
            if (q.rd_byte && q.rd_sel) rd_data = 16'h0000;
            else                       rd_data = {8'h00, rd_word[23:16]};
        end
    end

    assign page_q   = q.page;
    assign rd_valid = q.rd_valid;
    assign busy     = (q.st != ST_IDLE);

    // R10: nothing is read while an operation runs
    a_r10_no_read_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !rd_valid);

    // R3: read data follows one cycle after an accepted read
    a_r3_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(acc_valid && !acc_write && !prog_start && !busy));

    // R6: a single-instruction program holds busy for one cycle
    a_r6_single_short: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && q.st == ST_SINGLE) |=> !busy);

    // R11: the reserved operation code never starts anything
    a_r11_reserved_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && prog_start && prog_op == 2'b11) |=> !busy);
endmodule

// File: tb/sim_pmem_table_unit.sv
`timescale 1ns/1ps
module sim_pmem_table_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        page_we;
    logic [7:0]  page_wdata;
    logic [7:0]  page_q;
    logic        acc_valid, acc_write, acc_high, acc_byte;
    logic [15:0] acc_ea, acc_wdata;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic        prog_start;
    logic [1:0]  prog_op;
    logic [15:0] prog_ea;
    logic        busy;

    always #2.5 clk = ~clk;

    pmem_table_unit u0 (
        .clk(clk), .rst_n(rst_n),
        .page_we(page_we), .page_wdata(page_wdata), .page_q(page_q),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_high(acc_high),
        .acc_byte(acc_byte), .acc_ea(acc_ea), .acc_wdata(acc_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .prog_start(prog_start), .prog_op(prog_op), .prog_ea(prog_ea),
        .busy(busy)
    );

    int nchk = 0;
    int nfail = 0;
    bit reported = 0;

    // vector kinds
    localparam logic [2:0] K_WR = 3'd0, K_RD = 3'd1, K_PROG = 3'd2,
                           K_ERASE = 3'd3, K_PAGE = 3'd4;

    // {kind, high, byte, ea, data/expected, requirement}
    function automatic logic [40:0] v(logic [2:0] k, logic h, logic b,
                                      logic [15:0] ea, logic [15:0] dt, int r);
        return {k, h, b, ea, dt, 4'(r)};
    endfunction

    localparam int NV = 31;
    localparam logic [40:0] VEC [NV] = '{
        v(K_WR,    0, 0, 16'h0010, 16'h1234, 5),   // R5 low word to latch 8
        v(K_WR,    1, 0, 16'h0010, 16'hAB56, 5),   // R5 high word, wdata[15:8] dropped
        v(K_RD,    0, 0, 16'h0010, 16'hFFFF, 5),   // R5 array untouched before program
        v(K_PROG,  0, 0, 16'h0010, 16'h0000, 6),   // R6
        v(K_RD,    0, 0, 16'h0010, 16'h1234, 6),
        v(K_RD,    0, 1, 16'h0011, 16'h0012, 3),   // R3 upper low byte
        v(K_RD,    0, 1, 16'h0010, 16'h0034, 3),   // R3 lower low byte
        v(K_RD,    1, 0, 16'h0010, 16'h0056, 4),   // R4 high word
        v(K_RD,    1, 1, 16'h0011, 16'h0000, 4),   // R4 phantom byte
        v(K_RD,    1, 1, 16'h0010, 16'h0056, 4),
        v(K_WR,    0, 1, 16'h0010, 16'h00F0, 5),   // R5 lane 0 only
        v(K_PROG,  0, 0, 16'h0010, 16'h0000, 9),   // R9
        v(K_RD,    0, 0, 16'h0010, 16'h1230, 9),   // R9 1234 AND 12F0
        v(K_WR,    1, 1, 16'h0011, 16'h00AA, 5),   // R5 ignored lane
        v(K_PROG,  0, 0, 16'h0010, 16'h0000, 5),
        v(K_RD,    1, 0, 16'h0010, 16'h0056, 5),
        v(K_WR,    0, 1, 16'h0013, 16'h0077, 5),   // R5 lane 1 of latch 9
        v(K_PROG,  0, 0, 16'h0012, 16'h0000, 6),
        v(K_RD,    0, 0, 16'h0012, 16'h77FF, 5),
        v(K_ERASE, 0, 0, 16'h0010, 16'h0000, 8),   // R8
        v(K_RD,    0, 0, 16'h0010, 16'hFFFF, 8),
        v(K_RD,    1, 0, 16'h0012, 16'h00FF, 8),
        v(K_PAGE,  0, 0, 16'h0000, 16'h0080, 1),   // R1 config space
        v(K_WR,    0, 0, 16'h0004, 16'h0A0B, 1),
        v(K_PROG,  0, 0, 16'h0004, 16'h0000, 1),
        v(K_RD,    0, 0, 16'h0004, 16'h0A0B, 1),
        v(K_PAGE,  0, 0, 16'h0000, 16'h0000, 1),
        v(K_RD,    0, 0, 16'h0004, 16'hFFFF, 1),   // R1 user space untouched
        v(K_PAGE,  0, 0, 16'h0000, 16'h0001, 1),
        v(K_RD,    0, 0, 16'h0000, 16'hFFFF, 1),   // R1 beyond user depth
        v(K_PAGE,  0, 0, 16'h0000, 16'h0000, 1)
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        end
    endtask

    task automatic access(input logic w, input logic h, input logic b,
                          input logic [15:0] ea, input logic [15:0] dt);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = w; acc_high = h; acc_byte = b;
        acc_ea = ea; acc_wdata = dt;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic read_chk(input string req, input logic h, input logic b,
                            input logic [15:0] ea, input logic [15:0] exp);
        access(1'b0, h, b, ea, 16'h0000);
        check({req, " rd_valid"}, 32'(rd_valid), 32'd1);
        check({req, " rd_data"}, 32'(rd_data), 32'(exp));
    endtask

    task automatic prog(input logic [1:0] op, input logic [15:0] ea, output int n);
        @(negedge clk);
        prog_start = 1'b1; prog_op = op; prog_ea = ea;
        @(negedge clk);
        prog_start = 1'b0;
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic set_page(input logic [7:0] p);
        @(negedge clk);
        page_we = 1'b1; page_wdata = p;
        @(negedge clk);
        page_we = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: act=running exp=finished");
        report();
        $finish;
    end

    initial begin
        int n;
        rst_n = 1'b0;
        page_we = 0; page_wdata = 0;
        acc_valid = 0; acc_write = 0; acc_high = 0; acc_byte = 0;
        acc_ea = 0; acc_wdata = 0;
        prog_start = 0; prog_op = 0; prog_ea = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state and erased power-up contents (R2)
        check("R2 busy after reset", 32'(busy), 32'd0);
        check("R2 rd_valid after reset", 32'(rd_valid), 32'd0);
        check("R1 page_q after reset", 32'(page_q), 32'd0);
        read_chk("R2 low word", 1'b0, 1'b0, 16'h0400, 16'hFFFF);
        read_chk("R2 high byte", 1'b1, 1'b1, 16'h0400, 16'h00FF);
        @(negedge clk);
        check("R3 rd_valid single pulse", 32'(rd_valid), 32'd0);

        // vector walk
        for (int i = 0; i < NV; i++) begin
            logic [2:0]  k  = VEC[i][40:38];
            logic        h  = VEC[i][37];
            logic        b  = VEC[i][36];
            logic [15:0] ea = VEC[i][35:20];
            logic [15:0] dt = VEC[i][19:4];
            string tag = $sformatf("R%0d vec%0d", VEC[i][3:0], i);
            case (k)
                K_WR:    access(1'b1, h, b, ea, dt);
                K_RD:    read_chk(tag, h, b, ea, dt);
                K_PROG:  begin prog(2'b00, ea, n); check({tag, " busy"}, 32'(n), 32'd1); end
                K_ERASE: begin prog(2'b10, ea, n); check({tag, " busy"}, 32'(n), 32'd512); end
                default: begin set_page(dt[7:0]); check({tag, " page"}, 32'(page_q), 32'(dt[7:0])); end
            endcase
        end

        // R7: full row from unaligned start address
        for (int k = 0; k < 64; k++) begin
            access(1'b1, 1'b0, 1'b0, 16'h0080 + 16'(2 * k), 16'h5A00 + 16'(k));
            access(1'b1, 1'b1, 1'b0, 16'h0080 + 16'(2 * k), 16'(k));
        end
        prog(2'b01, 16'h00A6, n);
        check("R7 row busy cycles", 32'(n), 32'd64);
        for (int k = 0; k < 64; k++) begin
            read_chk("R7 row low", 1'b0, 1'b0, 16'h0080 + 16'(2 * k), 16'h5A00 + 16'(k));
        end
        read_chk("R7 row high first", 1'b1, 1'b0, 16'h0080, 16'h0000);
        read_chk("R7 row high last", 1'b1, 1'b0, 16'h00FE, 16'h003F);
        // latch entry 2 must be all ones again
        prog(2'b00, 16'h0104, n);
        read_chk("R7 latch reset", 1'b0, 1'b0, 16'h0104, 16'hFFFF);

        // R8 erase length, R10 accesses and starts during busy
        @(negedge clk);
        prog_start = 1'b1; prog_op = 2'b10; prog_ea = 16'h00A6;
        @(negedge clk);
        prog_start = 1'b0;
        n = 0;
        while (busy) begin
            n++;
            if (n == 3) begin
                acc_valid = 1'b1; acc_write = 1'b0; acc_high = 1'b0; acc_byte = 1'b0;
                acc_ea = 16'h0080;
            end
            if (n == 4) begin
                check("R10 no read while busy", 32'(rd_valid), 32'd0);
                acc_write = 1'b1; acc_ea = 16'h0200; acc_wdata = 16'h0000;
            end
            if (n == 5) begin
                acc_valid = 1'b0; acc_write = 1'b0;
                prog_start = 1'b1; prog_op = 2'b00; prog_ea = 16'h0080;
            end
            if (n == 6) prog_start = 1'b0;
            @(negedge clk);
        end
        check("R8 erase busy cycles", 32'(n), 32'd512);
        read_chk("R8 row erased", 1'b0, 1'b0, 16'h0080, 16'hFFFF);
        read_chk("R8 row erased high", 1'b1, 1'b0, 16'h00FE, 16'h00FF);
        prog(2'b00, 16'h0200, n);
        check("R6 single busy", 32'(n), 32'd1);
        read_chk("R10 write while busy ignored", 1'b0, 1'b0, 16'h0200, 16'hFFFF);

        // R10: access in the same cycle as a start is dropped
        @(negedge clk);
        prog_start = 1'b1; prog_op = 2'b00; prog_ea = 16'h0200;
        acc_valid = 1'b1; acc_write = 1'b0; acc_ea = 16'h0200;
        @(negedge clk);
        prog_start = 1'b0; acc_valid = 1'b0;
        check("R10 access with start dropped", 32'(rd_valid), 32'd0);
        while (busy) @(negedge clk);

        // R11: reserved operation
        access(1'b1, 1'b0, 1'b0, 16'h0200, 16'h0000);
        prog(2'b11, 16'h0200, n);
        check("R11 reserved op busy", 32'(n), 32'd0);
        read_chk("R11 reserved op no write", 1'b0, 1'b0, 16'h0200, 16'hFFFF);

        report();
        $finish;
    end
endmodule